// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps the results of executed stores out of memory until the reorder logic says they are final. When a store executes, the block places its address, data and program-order sequence number in one of a small set of fully associative slots, and marks the slot as speculative. A commit request clears the speculative mark. An abort request discards the slot. Committed slots then leave for the data cache one at a time, oldest first, over a valid/ready handshake. A slot is released only when the cache accepts it.

Loads search the buffer in the same cycle. Every occupied slot with the same address and a sequence number older than the load's is a candidate, and the load takes the data of the youngest candidate. This makes a later store win over an earlier one to the same address, and it keeps a load from seeing a store that follows it in program order. A forwarded value takes precedence over anything the cache holds. When there is no candidate, the load reports a miss and the cache supplies the data.

Sequence numbers are compared modulo 2^SEQW. Number `a` is older than number `b` when bit SEQW-1 of `(a - b) mod 2^SEQW` is 1. Numbers that are in flight together must therefore lie within half the sequence range of each other. Each slot runs a three-state machine. **FREE** goes to **SPEC** on *allocate*. **SPEC** goes to **DONE** on *commit*, or back to **FREE** on *abort*. **DONE** goes to **FREE** on *drain-accept*.

Top module: `spec_store_buf`

## Requirements
- R1: When `st_valid` and `st_ready` are both high at a clock edge, the store is written into the lowest-numbered free slot. `st_idx` reports that slot number in the same cycle. From the next cycle the slot is occupied and speculative.
- R2: `st_ready` is low exactly when all 8 slots are occupied. A store offered while `st_ready` is low is dropped, and a later load to its address sees no trace of it.
- R3: A commit (`cm_valid` with slot `cm_idx`) turns a speculative slot into a committed one. A commit aimed at a free slot or an already committed slot has no effect.
- R4: An abort (`ab_valid` with slot `ab_idx`) frees a speculative slot, and its data is never forwarded or drained. An abort aimed at a committed slot is ignored, and that slot still drains. When a commit and an abort target the same slot in the same cycle, the abort wins.
- R5: When `ld_valid` is high, `ld_hit` goes high and `ld_data` carries the data of the youngest occupied slot, speculative or committed, whose address equals `ld_addr` and whose sequence number is older than `ld_seq`. This happens in the same cycle.
- R6: When no occupied slot both matches `ld_addr` and is older than `ld_seq`, `ld_hit` is 0 and `ld_data` is 0. This covers loads that match only younger stores.
- R7: A speculative slot is never presented on the drain port. `dr_valid` is high only when the oldest occupied slot is committed.
- R8: Committed slots drain in program order. While `dr_valid` is high and `dr_ready` is low, `dr_valid`, `dr_addr` and `dr_data` hold steady. The slot is freed at the edge where both are high.
- R9: After reset all slots are free: `st_ready` is 1, `dr_valid` is 0 and `ld_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Executed store offered |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_seq | input | 8 | Store sequence number |
| st_ready | output | 1 | A free slot exists |
| st_idx | output | 3 | Slot the offered store will occupy |
| cm_valid | input | 1 | Commit request |
| cm_idx | input | 3 | Slot to commit |
| ab_valid | input | 1 | Abort request |
| ab_idx | input | 3 | Slot to abort |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load address |
| ld_seq | input | 8 | Load sequence number |
| ld_hit | output | 1 | Forwarded data available |
| ld_data | output | 32 | Forwarded data, 0 on miss |
| dr_valid | output | 1 | Committed slot offered to the cache |
| dr_ready | input | 1 | Cache accepts the offered slot |
| dr_addr | output | 32 | Address of the drained store |
| dr_data | output | 32 | Data of the drained store |

## Verification
The bound checker watches the following on every cycle:
- Allocations land only in free slots and become speculative.
- `st_ready` falls whenever every slot is occupied.
- Commits and aborts move slots to the right state.
- The drain offer holds while it is stalled.
- No drain occurs unless some commit is still waiting to leave.

The youngest-older-match choice for loads, the exclusion of younger stores, the program order of drains and the dropping of stores offered while full depend on values and on sequences of operations. Only the bench's scenarios show these, by comparing against an independent model and a scoreboard of expected drains.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_SPEC = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_t;
endpackage

// File: rtl/sb_entry.sv
module sb_entry
    import sb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int SEQW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic            commit,
    input  logic            abort,
    input  logic            drain_ack,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [SEQW-1:0] wr_seq,
    output logic            valid,
    output logic            spec,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   data,
    output logic [SEQW-1:0] seq
);
    ent_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc) state_d = ENT_SPEC;
            ENT_SPEC: begin
                if (abort)       state_d = ENT_FREE;
                else if (commit) state_d = ENT_DONE;
            end
            ENT_DONE: if (drain_ack) state_d = ENT_FREE;
            default:  state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            data <= '0;
            seq  <= '0;
        end else if (alloc && state_q == ENT_FREE) begin
            addr <= wr_addr;
            data <= wr_data;
            seq  <= wr_seq;
        end
    end

    always_comb begin
        valid = (state_q != ENT_FREE);
        spec  = (state_q == ENT_SPEC);
    end
endmodule

// File: rtl/sb_order.sv
module sb_order #(
    parameter int N    = 8,
    parameter int SEQW = 8,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]    valid_vec,
    input  logic [SEQW-1:0] seq_a [N],
    output logic            free_any,
    output logic [IW-1:0]   free_idx,
    output logic            old_any,
    output logic [IW-1:0]   old_idx
);
    function automatic logic is_older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
        logic [SEQW-1:0] d;
        d = a - b;
        return d[SEQW-1];
    endfunction

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    always_comb begin
        logic [SEQW-1:0] best_seq;
        old_any  = 1'b0;
        old_idx  = '0;
        best_seq = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_vec[i] && (!old_any || is_older(seq_a[i], best_seq))) begin
                old_any  = 1'b1;
                old_idx  = IW'(i);
                best_seq = seq_a[i];
            end
        end
    end
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
    parameter int N    = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int SEQW = 8
) (
    input  logic [N-1:0]    valid_vec,
    input  logic [AW-1:0]   addr_a [N],
    input  logic [DW-1:0]   data_a [N],
    input  logic [SEQW-1:0] seq_a  [N],
    input  logic            ld_valid,
    input  logic [AW-1:0]   ld_addr,
    input  logic [SEQW-1:0] ld_seq,
    output logic            hit,
    output logic [DW-1:0]   hit_data
);
    function automatic logic is_older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
        logic [SEQW-1:0] d;
        d = a - b;
        return d[SEQW-1];
    endfunction

    always_comb begin
        logic [SEQW-1:0] best_seq;
        hit      = 1'b0;
        hit_data = '0;
        best_seq = '0;
        for (int i = 0; i < N; i++) begin
            if (ld_valid && valid_vec[i] && addr_a[i] == ld_addr
                && is_older(seq_a[i], ld_seq)
                && (!hit || is_older(best_seq, seq_a[i]))) begin
                hit      = 1'b1;
                hit_data = data_a[i];
                best_seq = seq_a[i];
            end
        end
    end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
    parameter int N    = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int SEQW = 8,
    localparam int IW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_valid,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [SEQW-1:0] st_seq,
    output logic            st_ready,
    output logic [IW-1:0]   st_idx,
    input  logic            cm_valid,
    input  logic [IW-1:0]   cm_idx,
    input  logic            ab_valid,
    input  logic [IW-1:0]   ab_idx,
    input  logic            ld_valid,
    input  logic [AW-1:0]   ld_addr,
    input  logic [SEQW-1:0] ld_seq,
    output logic            ld_hit,
    output logic [DW-1:0]   ld_data,
    output logic            dr_valid,
    input  logic            dr_ready,
    output logic [AW-1:0]   dr_addr,
    output logic [DW-1:0]   dr_data
);
    logic [N-1:0]    valid_vec, spec_vec;
    logic [AW-1:0]   addr_a [N];
    logic [DW-1:0]   data_a [N];
    logic [SEQW-1:0] seq_a  [N];
    logic            free_any, old_any;
    logic [IW-1:0]   free_idx, old_idx;
    logic            st_fire, dr_fire;

    assign st_fire = st_valid && free_any;
    assign dr_fire = dr_valid && dr_ready;

    for (genvar g = 0; g < N; g++) begin : g_ent
        sb_entry #(.AW(AW), .DW(DW), .SEQW(SEQW)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (st_fire && free_idx == IW'(g)),
            .commit    (cm_valid && cm_idx == IW'(g)),
            .abort     (ab_valid && ab_idx == IW'(g)),
            .drain_ack (dr_fire && old_idx == IW'(g)),
            .wr_addr   (st_addr),
            .wr_data   (st_data),
            .wr_seq    (st_seq),
            .valid     (valid_vec[g]),
            .spec      (spec_vec[g]),
            .addr      (addr_a[g]),
            .data      (data_a[g]),
            .seq       (seq_a[g])
        );
    end

    sb_order #(.N(N), .SEQW(SEQW)) u_order (
        .valid_vec (valid_vec),
        .seq_a     (seq_a),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .old_any   (old_any),
        .old_idx   (old_idx)
    );

    sb_fwd #(.N(N), .AW(AW), .DW(DW), .SEQW(SEQW)) u_fwd (
        .valid_vec (valid_vec),
        .addr_a    (addr_a),
        .data_a    (data_a),
        .seq_a     (seq_a),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_seq    (ld_seq),
        .hit       (ld_hit),
        .hit_data  (ld_data)
    );

    always_comb begin
        st_ready = free_any;
        st_idx   = free_idx;
        dr_valid = old_any && !spec_vec[old_idx];
        dr_addr  = addr_a[old_idx];
        dr_data  = data_a[old_idx];
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int N    = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(N),
    localparam int CW  = $clog2(N) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic [IW-1:0] st_idx,
    input logic          cm_valid,
    input logic [IW-1:0] cm_idx,
    input logic          ab_valid,
    input logic [IW-1:0] ab_idx,
    input logic          dr_valid,
    input logic          dr_ready,
    input logic [AW-1:0] dr_addr,
    input logic [DW-1:0] dr_data,
    input logic [N-1:0]  valid_vec,
    input logic [N-1:0]  spec_vec
);
    logic [CW-1:0] pend_q;
    logic          cm_eff;

    assign cm_eff = cm_valid && spec_vec[cm_idx] && !(ab_valid && ab_idx == cm_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else pend_q <= pend_q + CW'(cm_eff) - CW'(dr_valid && dr_ready);
    end

    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |-> !valid_vec[st_idx]); // R1
    AST_ALLOC_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> spec_vec[$past(st_idx)]); // R1
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(valid_vec) == N) |-> !st_ready); // R2
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cm_eff |=> valid_vec[$past(cm_idx)] && !spec_vec[$past(cm_idx)]); // R3
    AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        ab_valid && spec_vec[ab_idx] |=> !valid_vec[$past(ab_idx)]); // R4
    AST_NO_SPEC_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> pend_q != '0); // R7
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data)); // R8
endmodule

bind spec_store_buf sb_checker #(.N(N), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_idx    (st_idx),
    .cm_valid  (cm_valid),
    .cm_idx    (cm_idx),
    .ab_valid  (ab_valid),
    .ab_idx    (ab_idx),
    .dr_valid  (dr_valid),
    .dr_ready  (dr_ready),
    .dr_addr   (dr_addr),
    .dr_data   (dr_data),
    .valid_vec (valid_vec),
    .spec_vec  (spec_vec)
);

// File: tb/spec_store_buf_bench.sv
`timescale 1ns/1ps
module spec_store_buf_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, cm_valid = 1'b0, ab_valid = 1'b0, ld_valid = 1'b0, dr_ready = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
    logic [7:0]  st_seq = '0, ld_seq = '0;
    logic [2:0]  cm_idx = '0, ab_idx = '0;
    logic        st_ready, ld_hit, dr_valid;
    logic [2:0]  st_idx;
    logic [31:0] ld_data, dr_addr, dr_data;

    always #2 clk = ~clk;

    spec_store_buf u_spec_store_buf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_seq(st_seq),
        .st_ready(st_ready), .st_idx(st_idx),
        .cm_valid(cm_valid), .cm_idx(cm_idx), .ab_valid(ab_valid), .ab_idx(ab_idx),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_seq(ld_seq), .ld_hit(ld_hit), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; int idx; } item_t;
    item_t exp_q[$];

    bit          m_v [N];
    bit          m_s [N];
    logic [31:0] m_a [N];
    logic [31:0] m_d [N];
    int          m_q [N];

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expected drains as the handshake happens
    always @(negedge clk) begin
        if (rst_n && dr_valid && dr_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected drain addr", dr_addr, 32'h0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(dr_addr == it.a, "R8", "drain order addr", dr_addr, it.a);
                chk(dr_data == it.d, "R8", "drain order data", dr_data, it.d);
                m_v[it.idx] = 0;
            end
        end
    end

    task automatic clear_in();
        st_valid = 0; cm_valid = 0; ab_valid = 0; ld_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1; clear_in();
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input int s);
        int exp_idx = -1;
        @(posedge clk); #1; clear_in();
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) exp_idx = i;
        st_valid = 1; st_addr = a; st_data = d; st_seq = 8'(s);
        @(negedge clk);
        if (exp_idx < 0) begin
            chk(st_ready == 0, "R2", "st_ready when full", 32'(st_ready), 32'h0);
        end else begin
            chk(st_ready == 1, "R1", "st_ready", 32'(st_ready), 32'h1);
            chk(st_idx == 3'(exp_idx), "R1", "st_idx lowest free", 32'(st_idx), 32'(exp_idx));
            m_v[exp_idx] = 1; m_s[exp_idx] = 1;
            m_a[exp_idx] = a; m_d[exp_idx] = d; m_q[exp_idx] = s;
        end
    endtask

    task automatic do_load(input logic [31:0] a, input int s, input string req);
        bit          eh = 0;
        int          bq = -1;
        logic [31:0] ed = '0;
        @(posedge clk); #1; clear_in();
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_a[i] == a && m_q[i] < s && m_q[i] > bq) begin
                eh = 1; bq = m_q[i]; ed = m_d[i];
            end
        ld_valid = 1; ld_addr = a; ld_seq = 8'(s);
        @(negedge clk);
        chk(ld_hit == eh, req, "ld_hit", 32'(ld_hit), 32'(eh));
        chk(ld_data == ed, req, "ld_data", ld_data, ed);
    endtask

    task automatic do_commit(input int idx);
        @(posedge clk); #1; clear_in();
        cm_valid = 1; cm_idx = 3'(idx);
        if (m_v[idx] && m_s[idx]) begin
            item_t it;
            m_s[idx] = 0;
            it.a = m_a[idx]; it.d = m_d[idx]; it.idx = idx;
            exp_q.push_back(it);
        end
    endtask

    task automatic do_abort(input int idx);
        @(posedge clk); #1; clear_in();
        ab_valid = 1; ab_idx = 3'(idx);
        if (m_v[idx] && m_s[idx]) m_v[idx] = 0;
    endtask

    task automatic check_offer(input bit ev, input logic [31:0] a, input logic [31:0] d, input string req);
        @(posedge clk); #1; clear_in();
        @(negedge clk);
        chk(dr_valid == ev, req, "dr_valid", 32'(dr_valid), 32'(ev));
        if (ev) begin
            chk(dr_addr == a, req, "dr_addr held", dr_addr, a);
            chk(dr_data == d, req, "dr_data held", dr_data, d);
        end
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "R9", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_s[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        ld_valid = 1; ld_addr = 32'h100; ld_seq = 8'd50;
        @(negedge clk);
        chk(st_ready == 1, "R9", "reset st_ready", 32'(st_ready), 32'h1);
        chk(dr_valid == 0, "R9", "reset dr_valid", 32'(dr_valid), 32'h0);
        chk(ld_hit == 0,   "R9", "reset ld_hit", 32'(ld_hit), 32'h0);

        // R1 / R5 / R6: forwarding picks youngest older match
        do_store(32'h100, 32'hAAAA_0001, 10);
        do_store(32'h100, 32'hBBBB_0002, 12);
        do_store(32'h200, 32'hCCCC_0003, 14);
        do_load(32'h100, 13, "R5");   // youngest older = seq 12
        do_load(32'h100, 11, "R5");   // only seq 10 older
        do_load(32'h100, 9,  "R6");   // matches only younger stores
        do_load(32'h300, 20, "R6");   // no match
        check_offer(0, '0, '0, "R7"); // all speculative

        // R4: abort frees slot and hides its data
        do_abort(1);
        do_load(32'h100, 13, "R4");
        do_store(32'h100, 32'hDDDD_0004, 16); // reuses slot 1
        do_load(32'h100, 20, "R5");

        // R3 / R8: commit in order, stalled drain holds
        dr_ready = 0;
        do_commit(0);
        check_offer(1, 32'h100, 32'hAAAA_0001, "R8");
        check_offer(1, 32'h100, 32'hAAAA_0001, "R8");
        do_commit(0);                 // R3: second commit to committed slot ignored
        do_commit(2);
        do_commit(1);
        do_abort(2);                  // R4: abort of committed slot ignored
        do_load(32'h200, 20, "R4");
        dr_ready = 1;
        idle(6);
        chk(exp_q.size() == 0, "R8", "all committed drained", 32'(exp_q.size()), 32'h0);
        check_offer(0, '0, '0, "R8");
        do_load(32'h100, 20, "R6");

        // R2: fill, then offer while full
        dr_ready = 0;
        for (int i = 0; i < N; i++) do_store(32'h400 + 32'(i * 4), 32'h5000 + 32'(i), 30 + i);
        do_store(32'h999, 32'hDEAD_BEEF, 40);
        do_load(32'h999, 60, "R2");
        do_commit(3);                 // R3: out-of-turn commit; oldest is still speculative
        check_offer(0, '0, '0, "R7");
        for (int i = 0; i < N; i++) if (i != 3) do_commit(i);
        for (int i = 0; i < N; i++) exp_q.sort() with (item.a);
        do_load(32'h404, 60, "R5");   // committed slot still forwards
        for (int k = 0; k < 24; k++) begin
            @(posedge clk); #1; clear_in(); dr_ready = k[0];
        end
        chk(exp_q.size() == 0, "R8", "fill drained", 32'(exp_q.size()), 32'h0);
        do_store(32'h600, 32'h7777, 50);
        do_store(32'h600, 32'h8888, 51);
        // R4: commit and abort on same slot in one cycle -> abort wins
        @(posedge clk); #1; clear_in();
        cm_valid = 1; cm_idx = 3'd1; ab_valid = 1; ab_idx = 3'd1;
        m_v[1] = 0;
        do_load(32'h600, 60, "R4");
        idle(2);
        finish_run();
    end
endmodule